// File: doc/BRIEF.md
# Dual-Master Peripheral Security Filter

This block sits in the path of a shared register bus that two CPUs drive, one access per cycle. Each access carries a master identifier, a read/write flag, an instruction-fetch flag, an address and write data. The filter decodes the address into its own register window, three guarded peripheral windows (random-number generator, public-key engine and cipher engine), an SRAM window, or everything else. It then decides in the same cycle whether the access goes downstream, is answered with a bus error, or is completed locally with zero read data.

The trusted second CPU (`req_master` = 1) owns a security control word. In that word, one bit per guarded peripheral restricts the first CPU (`req_master` = 0). A restricted write from the first CPU is dropped and flagged as an error. A restricted read is completed with zero data and no error. A separate sticky lock bit stops the second CPU from fetching instructions out of SRAM. If the public-key secure bit is set when a system reset arrives, the filter pulses an erase request for that engine's RAM once the reset ends. That state survives the system reset and is cleared only by the power-on reset.

Top module: `periph_sec_filter`

## Requirements
- R1: After reset (`rst_n` or `por_n` low at a clock edge), all three secure bits and the fetch lock read 0, and accesses from either master to any peripheral window are forwarded (`dn_valid` = 1).
- R2: A write by master 1 to the control word at address 0x0010 loads the secure bits from write-data bit 3 (random-number), bit 2 (public-key) and bit 1 (cipher). These take effect at the next clock edge. Control-word bits 0 and 31:4 always read 0.
- R3: A write by master 0 to the control word is not applied and returns `rsp_err` = 1 in the same cycle.
- R4: A read of the control word by either master returns its current value with `rsp_err` = 0.
- R5: With a peripheral's secure bit at 1, a master-0 write into its window (random-number 0x0100–0x01FF, public-key 0x0200–0x02FF, cipher 0x0300–0x03FF) is not forwarded and returns `rsp_err` = 1.
- R6: With a peripheral's secure bit at 1, a master-0 read of its window is not forwarded and returns `rsp_rdata` = 0 with `rsp_err` = 0.
- R7: A forwarded access has `dn_valid` = 1, `rsp_rdata` = `dn_rdata` and `rsp_err` = `dn_err`. This applies to master 1, to master 0 when the secure bit is 0, and to unguarded addresses.
- R8: The fetch lock is bit 0 of the word at 0x0014. Writing 1 from either master sets it. Writing 0 leaves it unchanged. Only reset clears it.
- R9: While the lock is 1, an instruction fetch (`req_fetch` = 1) by master 1 from the SRAM window 0x8000–0xFFFF is not forwarded and returns `rsp_err` = 1. Data reads, master-0 fetches and fetches outside SRAM are unaffected.
- R10: If the public-key secure bit is 1 at the first edge of a system reset (`rst_n` low, `por_n` high), `pka_erase_req` is 1 for exactly the one cycle that follows the first clock edge with `rst_n` high. Otherwise it stays 0, including after a power-on reset.
- R11: Accesses to the register window 0x0000–0x00FF are never forwarded. Writes to unused offsets there are dropped without error, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| por_n | input | 1 | Synchronous active-low power-on reset, also clears the erase capture |
| req_valid | input | 1 | Access present this cycle |
| req_master | input | 1 | 0 = first CPU, 1 = second (trusted) CPU |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write data |
| rsp_err | output | 1 | Bus error for this access |
| rsp_rdata | output | DW | Read data for this access |
| dn_valid | output | 1 | Access forwarded downstream |
| dn_write | output | 1 | Forwarded write flag |
| dn_addr | output | AW | Forwarded address |
| dn_wdata | output | DW | Forwarded write data |
| dn_rdata | input | DW | Downstream read data |
| dn_err | input | 1 | Downstream error |
| pka_erase_req | output | 1 | One-cycle public-key RAM erase request after reset |

## Verification
The hardest situation to reach is the erase request. It depends on state carried across a system reset, so the bench must first program the public-key secure bit through a master-1 write. It then pulls `rst_n` low for several cycles and checks the output on the edge after release and on the edge after that. It repeats the sequence with the bit clear, and then with a power-on reset, to show that neither produces a pulse. The fetch lock is also reached only through ordering: the bench sets it, tries to clear it, and then compares a master-1 fetch against a master-1 data read and a master-0 fetch to the same SRAM address.

// File: rtl/sf_pkg.sv
// Package: shared constants and types for the peripheral security filter.
// Assumes a 16-bit byte address space and one access per cycle.
package sf_pkg;
    localparam int AW_DEF        = 16;
    localparam int DW_DEF        = 32;
    localparam int NPERIPH       = 3;      // guarded peripherals
    localparam int SEC_LSB       = 1;      // secure bits occupy [SEC_LSB +: NPERIPH]
    localparam int IDX_CIPHER    = 0;      // control bit 1
    localparam int IDX_PKA       = 1;      // control bit 2
    localparam int IDX_RNG       = 2;      // control bit 3
    localparam int PWIN_BITS     = 8;      // peripheral window size = 2**PWIN_BITS
    localparam int RWIN_BITS     = 8;      // own register window size
    localparam int SWIN_BITS     = 15;     // SRAM window size
    localparam logic [AW_DEF-1:0] REG_BASE  = 16'h0000;
    localparam logic [AW_DEF-1:0] CTL_OFS   = 16'h0010;
    localparam logic [AW_DEF-1:0] LOCK_OFS  = 16'h0014;
    localparam logic [AW_DEF-1:0] SRAM_BASE = 16'h8000;
    // flattened peripheral bases, index 0 in the low slice
    localparam logic [NPERIPH*AW_DEF-1:0] PBASE_FLAT = {16'h0100, 16'h0200, 16'h0300};

    typedef enum logic {
        MST_APP = 1'b0,   // first CPU, subject to restriction
        MST_SEC = 1'b1    // second CPU, owns the control word
    } master_e;
endpackage

// File: rtl/sf_decode.sv
// Address decoder: flags which window an address falls in.
// Assumes windows are aligned to their power-of-two sizes and do not overlap.
module sf_decode #(
    parameter int AW        = sf_pkg::AW_DEF,
    parameter int NP        = sf_pkg::NPERIPH,
    parameter int PWIN      = sf_pkg::PWIN_BITS,
    parameter int RWIN      = sf_pkg::RWIN_BITS,
    parameter int SWIN      = sf_pkg::SWIN_BITS,
    parameter logic [AW-1:0]    RBASE = sf_pkg::REG_BASE,
    parameter logic [AW-1:0]    SBASE = sf_pkg::SRAM_BASE,
    parameter logic [NP*AW-1:0] PBASE = sf_pkg::PBASE_FLAT
) (
    input  logic [AW-1:0] addr,
    output logic          hit_reg,
    output logic [NP-1:0] hit_periph,
    output logic          hit_sram,
    output logic [AW-1:0] reg_ofs
);
    localparam logic [AW-1:0] RMASK = AW'((1 << RWIN) - 1);

    // own register window and offset inside it
    assign hit_reg  = (addr[AW-1:RWIN] == RBASE[AW-1:RWIN]);
    assign reg_ofs  = addr & RMASK;
    // SRAM window
    assign hit_sram = (addr[AW-1:SWIN] == SBASE[AW-1:SWIN]);

    // one comparator per guarded peripheral window
    for (genvar g = 0; g < NP; g++) begin : g_pwin
        localparam logic [AW-1:0] BASE_G = PBASE[g*AW +: AW];
        assign hit_periph[g] = (addr[AW-1:PWIN] == BASE_G[AW-1:PWIN]);
    end
endmodule

// File: rtl/sf_regs.sv
// State: secure bits, sticky fetch lock, and erase-request capture.
// Assumes rst_n and por_n are synchronous; por_n also clears the capture
// flop that survives a system reset.
module sf_regs #(
    parameter int NP      = sf_pkg::NPERIPH,
    parameter int PKA_IDX = sf_pkg::IDX_PKA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_n,
    input  logic          ctl_we,
    input  logic [NP-1:0] ctl_wdata,
    input  logic          lock_we,
    input  logic          lock_wbit,
    output logic [NP-1:0] sec_q,
    output logic          lock_q,
    output logic          erase_req
);
    logic in_rst;      // 1 while a reset was seen at the last edge
    logic pka_shadow;  // public-key secure bit as it stood when reset hit

    // secure bits: loaded by an allowed control-word write
    always_ff @(posedge clk) begin
        if (!rst_n || !por_n) sec_q <= '0;
        else if (ctl_we)      sec_q <= ctl_wdata;
    end

    // fetch lock: set-only, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n || !por_n)          lock_q <= 1'b0;
        else if (lock_we && lock_wbit) lock_q <= 1'b1;
    end

    // reset-seen marker used to time the release pulse
    always_ff @(posedge clk) begin
        if (!rst_n || !por_n) in_rst <= 1'b1;
        else                  in_rst <= 1'b0;
    end

    // shadow follows the bit outside reset and freezes on the first reset edge
    always_ff @(posedge clk) begin
        if (!por_n)       pka_shadow <= 1'b0;
        else if (!in_rst) pka_shadow <= sec_q[PKA_IDX];
    end

    // erase pulse in the cycle after the first edge out of reset
    always_ff @(posedge clk) begin
        if (!rst_n || !por_n) erase_req <= 1'b0;
        else                  erase_req <= in_rst && pka_shadow;
    end
endmodule

// File: rtl/sf_gate.sv
// Access gate: decides forward, error or local completion for one access.
// Purely combinational; the response belongs to the same cycle as the access.
module sf_gate #(
    parameter int AW = sf_pkg::AW_DEF,
    parameter int DW = sf_pkg::DW_DEF,
    parameter int NP = sf_pkg::NPERIPH,
    parameter int SLSB = sf_pkg::SEC_LSB,
    parameter logic [AW-1:0] CTL_OFS  = sf_pkg::CTL_OFS,
    parameter logic [AW-1:0] LOCK_OFS = sf_pkg::LOCK_OFS
) (
    input  logic          req_valid,
    input  logic          req_master,
    input  logic          req_write,
    input  logic          req_fetch,
    input  logic          hit_reg,
    input  logic [NP-1:0] hit_periph,
    input  logic          hit_sram,
    input  logic [AW-1:0] reg_ofs,
    input  logic [NP-1:0] sec_q,
    input  logic          lock_q,
    input  logic [DW-1:0] dn_rdata,
    input  logic          dn_err,
    output logic          dn_valid,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_rdata,
    output logic          ctl_we,
    output logic          lock_we
);
    import sf_pkg::*;

    logic          is_ctl, is_lock, from_app, periph_guard, fetch_guard;
    logic [DW-1:0] ctl_word, lock_word;

    assign is_ctl      = hit_reg && (reg_ofs == CTL_OFS);
    assign is_lock     = hit_reg && (reg_ofs == LOCK_OFS);
    assign from_app    = (master_e'(req_master) == MST_APP);
    assign periph_guard = from_app && |(hit_periph & sec_q);
    assign fetch_guard = hit_sram && req_fetch && !from_app && lock_q;

    // read views of the two local words
    always_comb begin
        ctl_word = '0;
        ctl_word[SLSB +: NP] = sec_q;
        lock_word = '0;
        lock_word[0] = lock_q;
    end

    // per-access routing decision
    always_comb begin
        dn_valid  = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        ctl_we    = 1'b0;
        lock_we   = 1'b0;
        if (req_valid) begin
            if (hit_reg) begin
                if (is_ctl) begin
                    if (req_write) begin
                        if (from_app) rsp_err = 1'b1;
                        else          ctl_we  = 1'b1;
                    end else begin
                        rsp_rdata = ctl_word;
                    end
                end else if (is_lock) begin
                    if (req_write) lock_we   = 1'b1;
                    else           rsp_rdata = lock_word;
                end
            end else if (periph_guard) begin
                rsp_err = req_write;
            end else if (fetch_guard) begin
                rsp_err = 1'b1;
            end else begin
                dn_valid  = 1'b1;
                rsp_err   = dn_err;
                rsp_rdata = dn_rdata;
            end
        end
    end
endmodule

// File: rtl/periph_sec_filter.sv
// Top: master-aware security filter on a shared single-cycle register bus.
// Assumes one access per cycle and a downstream that answers in that cycle.
module periph_sec_filter #(
    parameter int AW = sf_pkg::AW_DEF,
    parameter int DW = sf_pkg::DW_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_n,
    input  logic          req_valid,
    input  logic          req_master,
    input  logic          req_write,
    input  logic          req_fetch,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_rdata,
    output logic          dn_valid,
    output logic          dn_write,
    output logic [AW-1:0] dn_addr,
    output logic [DW-1:0] dn_wdata,
    input  logic [DW-1:0] dn_rdata,
    input  logic          dn_err,
    output logic          pka_erase_req
);
    import sf_pkg::*;
    localparam int NP = NPERIPH;

    logic          hit_reg, hit_sram, ctl_we, lock_we, lock_q;
    logic [NP-1:0] hit_periph, sec_q;
    logic [AW-1:0] reg_ofs;

    sf_decode #(.AW(AW), .NP(NP)) u_dec (
        .addr(req_addr), .hit_reg(hit_reg), .hit_periph(hit_periph),
        .hit_sram(hit_sram), .reg_ofs(reg_ofs)
    );

    sf_gate #(.AW(AW), .DW(DW), .NP(NP)) u_gate (
        .req_valid(req_valid), .req_master(req_master), .req_write(req_write),
        .req_fetch(req_fetch), .hit_reg(hit_reg), .hit_periph(hit_periph),
        .hit_sram(hit_sram), .reg_ofs(reg_ofs), .sec_q(sec_q), .lock_q(lock_q),
        .dn_rdata(dn_rdata), .dn_err(dn_err), .dn_valid(dn_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .ctl_we(ctl_we), .lock_we(lock_we)
    );

    sf_regs #(.NP(NP)) u_regs (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .ctl_we(ctl_we),
        .ctl_wdata(req_wdata[SEC_LSB +: NP]), .lock_we(lock_we),
        .lock_wbit(req_wdata[0]), .sec_q(sec_q), .lock_q(lock_q),
        .erase_req(pka_erase_req)
    );

    // request fields travel downstream unchanged; dn_valid gates them
    assign dn_write = req_write;
    assign dn_addr  = req_addr;
    assign dn_wdata = req_wdata;
endmodule

// File: rtl/sf_checker.sv
// Checker: temporal properties of the filter, bound to the top module.
module sf_checker #(
    parameter int AW = sf_pkg::AW_DEF,
    parameter int DW = sf_pkg::DW_DEF,
    parameter int NP = sf_pkg::NPERIPH
) (
    input logic          clk,
    input logic          rst_n,
    input logic          por_n,
    input logic          req_valid,
    input logic          req_master,
    input logic          req_write,
    input logic          req_fetch,
    input logic [AW-1:0] req_addr,
    input logic [DW-1:0] req_wdata,
    input logic          dn_valid,
    input logic          rsp_err,
    input logic [DW-1:0] rsp_rdata,
    input logic [NP-1:0] sec_q,
    input logic          lock_q,
    input logic          pka_erase_req
);
    import sf_pkg::*;
    localparam logic [AW-1:0] CTL_ADDR = REG_BASE | CTL_OFS;

    logic ctl_acc, own_win, sram_win;
    assign ctl_acc  = req_valid && req_write && (req_addr == CTL_ADDR);
    assign own_win  = req_addr[AW-1:RWIN_BITS] == REG_BASE[AW-1:RWIN_BITS];
    assign sram_win = req_addr[AW-1:SWIN_BITS] == SRAM_BASE[AW-1:SWIN_BITS];

    AST_APP_CTL_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        ctl_acc && !req_master |-> rsp_err && !dn_valid); // R3
    AST_APP_CTL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        ctl_acc && !req_master |=> $stable(sec_q)); // R3
    AST_SEC_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        ctl_acc && req_master |=> sec_q == $past(req_wdata[SEC_LSB +: NP])); // R2
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        lock_q |=> lock_q); // R8
    AST_FETCH_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        req_valid && req_master && req_fetch && sram_win && lock_q |-> rsp_err && !dn_valid); // R9
    AST_ERASE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        pka_erase_req |=> !pka_erase_req); // R10
    AST_OWN_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        req_valid && own_win |-> !dn_valid); // R11

    for (genvar g = 0; g < NP; g++) begin : g_pchk
        localparam logic [AW-1:0] BASE_G = PBASE_FLAT[g*AW +: AW];
        logic in_win;
        assign in_win = req_addr[AW-1:PWIN_BITS] == BASE_G[AW-1:PWIN_BITS];
        AST_APP_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
            req_valid && !req_master && req_write && in_win && sec_q[g] |-> rsp_err && !dn_valid); // R5
        AST_APP_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
            req_valid && !req_master && !req_write && in_win && sec_q[g]
            |-> rsp_rdata == '0 && !rsp_err && !dn_valid); // R6
    end
endmodule

bind periph_sec_filter sf_checker #(.AW(AW), .DW(DW)) u_sf_chk (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .req_valid(req_valid),
    .req_master(req_master), .req_write(req_write), .req_fetch(req_fetch),
    .req_addr(req_addr), .req_wdata(req_wdata), .dn_valid(dn_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .sec_q(sec_q), .lock_q(lock_q),
    .pka_erase_req(pka_erase_req)
);

// File: tb/periph_sec_filter_bench.sv
module periph_sec_filter_bench;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0, por_n = 1'b0;
    logic          req_valid = 1'b0, req_master = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0, dn_rdata = '0;
    logic          dn_err = 1'b0;
    logic          rsp_err, dn_valid, dn_write, pka_erase_req;
    logic [DW-1:0] rsp_rdata, dn_wdata;
    logic [AW-1:0] dn_addr;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    periph_sec_filter u_periph_sec_filter (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .req_valid(req_valid),
        .req_master(req_master), .req_write(req_write), .req_fetch(req_fetch),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .dn_valid(dn_valid), .dn_write(dn_write),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata),
        .dn_err(dn_err), .pka_erase_req(pka_erase_req)
    );

    typedef struct packed {
        logic        m;    // master
        logic        w;    // write
        logic        f;    // fetch
        logic [15:0] a;    // address
        logic [31:0] wd;   // write data
        logic [31:0] dr;   // downstream read data
        logic        de;   // downstream error
        logic        xf;   // expected dn_valid
        logic        xe;   // expected rsp_err
        logic [31:0] xr;   // expected rsp_rdata
        logic [7:0]  rq;   // requirement number
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,16'h0100,32'h0,32'h0000A5A5,1'b0, 1'b1,1'b0,32'h0000A5A5, 8'd1}, // R1
        '{1'b0,1'b1,1'b0,16'h0204,32'h9,32'h0,       1'b0, 1'b1,1'b0,32'h0,        8'd1}, // R1
        '{1'b0,1'b0,1'b0,16'h0010,32'h0,32'hFFFF,    1'b0, 1'b0,1'b0,32'h0,        8'd4}, // R4
        '{1'b0,1'b1,1'b0,16'h0010,32'hE,32'h0,       1'b0, 1'b0,1'b1,32'h0,        8'd3}, // R3
        '{1'b1,1'b0,1'b0,16'h0010,32'h0,32'h0,       1'b0, 1'b0,1'b0,32'h0,        8'd3}, // R3
        '{1'b1,1'b1,1'b0,16'h0010,32'hFFFFFFFF,32'h0,1'b0, 1'b0,1'b0,32'h0,        8'd2}, // R2
        '{1'b0,1'b0,1'b0,16'h0010,32'h0,32'h0,       1'b0, 1'b0,1'b0,32'hE,        8'd2}, // R2
        '{1'b0,1'b1,1'b0,16'h0108,32'h1,32'h0,       1'b0, 1'b0,1'b1,32'h0,        8'd5}, // R5
        '{1'b0,1'b0,1'b0,16'h0310,32'h0,32'h1234,    1'b0, 1'b0,1'b0,32'h0,        8'd6}, // R6
        '{1'b1,1'b0,1'b0,16'h0310,32'h0,32'h1234,    1'b0, 1'b1,1'b0,32'h1234,     8'd7}, // R7
        '{1'b1,1'b1,1'b0,16'h0200,32'h3,32'h0,       1'b0, 1'b1,1'b0,32'h0,        8'd7}, // R7
        '{1'b0,1'b0,1'b0,16'h0400,32'h0,32'h77,      1'b1, 1'b1,1'b1,32'h77,       8'd7}, // R7
        '{1'b1,1'b1,1'b0,16'h0010,32'h4,32'h0,       1'b0, 1'b0,1'b0,32'h0,        8'd2}, // R2
        '{1'b1,1'b0,1'b0,16'h0010,32'h0,32'h0,       1'b0, 1'b0,1'b0,32'h4,        8'd4}, // R4
        '{1'b0,1'b1,1'b0,16'h0100,32'h5,32'h0,       1'b0, 1'b1,1'b0,32'h0,        8'd7}, // R7
        '{1'b0,1'b1,1'b0,16'h02FC,32'h5,32'h0,       1'b0, 1'b0,1'b1,32'h0,        8'd5}, // R5
        '{1'b0,1'b1,1'b0,16'h0020,32'h1,32'h0,       1'b0, 1'b0,1'b0,32'h0,        8'd11}, // R11
        '{1'b1,1'b0,1'b0,16'h0024,32'h0,32'h99,      1'b0, 1'b0,1'b0,32'h0,        8'd11}  // R11
    };

    task automatic check(input bit ok, input int rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic access(input vec_t v);
        @(negedge clk);
        req_valid = 1'b1; req_master = v.m; req_write = v.w; req_fetch = v.f;
        req_addr = v.a; req_wdata = v.wd; dn_rdata = v.dr; dn_err = v.de;
        #5;
        check({dn_valid, rsp_err, rsp_rdata} == {v.xf, v.xe, v.xr}, int'(v.rq),
              "fwd/err/rdata", {dn_valid, rsp_err, rsp_rdata[29:0]},
              {v.xf, v.xe, v.xr[29:0]});
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic erase_watch(input bit exp_pulse, input int rq);
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(pka_erase_req == 1'b0, rq, "erase during reset", 32'(pka_erase_req), 32'h0);
        rst_n = 1'b1;
        @(posedge clk); #5;
        check(pka_erase_req == exp_pulse, rq, "erase after release", 32'(pka_erase_req), 32'(exp_pulse));
        @(posedge clk); #5;
        check(pka_erase_req == 1'b0, rq, "erase second cycle", 32'(pka_erase_req), 32'h0);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            fails++;
            $display("FAIL watchdog expired, all requirements unfinished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pka_erase_req == 1'b0, 1, "erase in power-on reset", 32'(pka_erase_req), 32'h0); // R1
        por_n = 1'b1; rst_n = 1'b1;
        @(posedge clk); #5;
        check(pka_erase_req == 1'b0, 10, "no erase after power-on", 32'(pka_erase_req), 32'h0); // R10

        for (int i = 0; i < NV; i++) access(VECS[i]);

        // fetch lock, R8 and R9
        access('{1'b1,1'b0,1'b1,16'h8000,32'h0,32'h55,1'b0, 1'b1,1'b0,32'h55, 8'd9});
        access('{1'b0,1'b1,1'b0,16'h0014,32'h1,32'h0, 1'b0, 1'b0,1'b0,32'h0,  8'd8});
        access('{1'b1,1'b0,1'b0,16'h0014,32'h0,32'h0, 1'b0, 1'b0,1'b0,32'h1,  8'd8});
        access('{1'b1,1'b1,1'b0,16'h0014,32'h0,32'h0, 1'b0, 1'b0,1'b0,32'h0,  8'd8});
        access('{1'b0,1'b0,1'b0,16'h0014,32'h0,32'h0, 1'b0, 1'b0,1'b0,32'h1,  8'd8});
        access('{1'b1,1'b0,1'b1,16'h9000,32'h0,32'h66,1'b0, 1'b0,1'b1,32'h0,  8'd9});
        access('{1'b1,1'b0,1'b0,16'h9000,32'h0,32'h66,1'b0, 1'b1,1'b0,32'h66, 8'd9});
        access('{1'b0,1'b0,1'b1,16'h9000,32'h0,32'h67,1'b0, 1'b1,1'b0,32'h67, 8'd9});
        access('{1'b1,1'b0,1'b1,16'h0500,32'h0,32'h68,1'b0, 1'b1,1'b0,32'h68, 8'd9});

        // public-key bit is 1 here: reset must pulse the erase, R10
        erase_watch(1'b1, 10);
        // R1 and R8: state cleared by the system reset
        access('{1'b1,1'b0,1'b0,16'h0010,32'h0,32'h0,1'b0, 1'b0,1'b0,32'h0, 8'd1});
        access('{1'b1,1'b0,1'b0,16'h0014,32'h0,32'h0,1'b0, 1'b0,1'b0,32'h0, 8'd8});
        // public-key bit clear: no pulse, R10
        erase_watch(1'b0, 10);
        // only the random-number bit set: no pulse, R10
        access('{1'b1,1'b1,1'b0,16'h0010,32'h8,32'h0,1'b0, 1'b0,1'b0,32'h0, 8'd2});
        erase_watch(1'b0, 10);

        // power-on reset with public-key bit set: no pulse, R10
        access('{1'b1,1'b1,1'b0,16'h0010,32'h4,32'h0,1'b0, 1'b0,1'b0,32'h0, 8'd2});
        @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(posedge clk); #5;
        check(pka_erase_req == 1'b0, 10, "no erase after power-on", 32'(pka_erase_req), 32'h0);
        @(posedge clk); #5;
        check(pka_erase_req == 1'b0, 10, "no erase later", 32'(pka_erase_req), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule